// File: doc/BRIEF.md
# Transmit Status Word Tracker

This block follows one half-duplex Ethernet transmit attempt from its start to its end and condenses what happened into a status word. The MAC transmit engine feeds it single-cycle pulses: the attempt starting, each collision, a deferral opening and closing, a bit-time tick, a data FIFO underrun, and a successful finish. From these it counts collisions, times deferral in bit times, decides when the attempt must be given up, and packs the outcome into flag and count fields.

A control FSM with three named states drives the block. `ST_IDLE` waits for `frame_start`; the transition IDLE->ACTIVE clears every counter and flag. `ST_ACTIVE` accepts events and watches for an ending cause. When it sees one, it takes the transition ACTIVE->REPORT and latches the packed word. `ST_REPORT` lasts exactly one cycle: it raises `status_valid` and, if the attempt was given up, `abort_req`. The transition REPORT->IDLE then follows unconditionally. In the same cycle, several ending causes are ranked with underrun first, then excessive collisions, then excessive deferral, then normal completion.

A separate underrun error flag stays set after an underrun until the host pulses `udf_clr`. Status word layout: bit 0 deferred, bit 1 underrun, bit 2 excessive deferral, bits 6:3 collision count, bit 8 excessive collisions. Bit 7 and all bits above 8 are reserved.

Top module: `tx_status_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, `status_valid`, `abort_req`, `udf_err` and the whole `status_word` are zero.
- R2: The IDLE->ACTIVE transition clears the collision count, the deferral timer and all flags, so each reported word reflects only the events of its own attempt.
- R3: A `tx_done` pulse sampled in ACTIVE makes `status_valid` high for exactly the next cycle with `abort_req` low, and bits 6:3 carry the number of collisions seen (0 to 15).
- R4: The 16th collision of an attempt ends it at once with `abort_req` high, bit 8 set and bits 6:3 reading zero.
- R5: Bit 0 is set when at least one deferral began during the attempt, whatever the attempt's outcome.
- R6: With `defer_chk_en` high, once a single deferral has counted more than 24288 bit-time ticks the attempt ends with `abort_req` high and bits 2 and 0 set. Exactly 24288 ticks does not end it.
- R7: With `defer_chk_en` low, no deferral length ends the attempt, and bit 2 stays clear.
- R8: The deferral timer advances only on `bit_tick` pulses while a deferral is open, saturates at one past the limit, and restarts at each new deferral.
- R9: An underrun in ACTIVE ends the attempt with `abort_req` high and bit 1 set. It also sets `udf_err` from the next cycle, and `udf_err` stays set until `udf_clr` clears it one cycle later.
- R10: Bit 7 and every bit above bit 8 always read zero.
- R11: If several ending causes coincide, only the highest-ranked one (underrun, excessive collisions, excessive deferral, completion) is flagged.
- R12: Event pulses that arrive outside ACTIVE have no effect on any output or on the next reported word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse: a new transmit attempt begins |
| coll_pulse | input | 1 | Pulse: one collision observed |
| defer_begin | input | 1 | Pulse: transmitter starts deferring |
| defer_end | input | 1 | Pulse: deferral is over |
| bit_tick | input | 1 | Pulse once per bit time |
| fifo_underrun | input | 1 | Pulse: transmit data FIFO ran dry |
| tx_done | input | 1 | Pulse: frame sent successfully |
| defer_chk_en | input | 1 | Enables the excessive-deferral abort |
| udf_clr | input | 1 | Pulse: clears the sticky underrun error |
| status_word | output | STATUS_W | Packed outcome, valid with `status_valid` |
| status_valid | output | 1 | One-cycle strobe when the attempt ends |
| abort_req | output | 1 | High with the strobe when the attempt was given up |
| udf_err | output | 1 | Sticky underrun error flag |

## Verification
Every ending cause is registered once on the way to REPORT. So `status_valid`, `status_word` and `abort_req` appear in the cycle after the edge that samples the ending pulse, and `udf_err` rises on that same edge. Excessive deferral is one cycle later than that: the tick that pushes the timer past the limit lands on one edge, and the FSM reacts on the next. The bench drives every input on the falling edge and samples on the following falling edge. It checks that the strobe is absent before its cycle, present in it and gone one cycle after. For the deferral limit it counts ticks exactly, so the boundary is checked to the cycle.

// File: rtl/txst_pkg.sv
package txst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_REPORT
    } txst_state_e;

    typedef enum logic [2:0] {
        END_NONE,
        END_DONE,
        END_UNDERRUN,
        END_EXC_COLL,
        END_EXC_DEFER
    } txst_end_e;

    // Field positions of the packed status word
    localparam int unsigned BIT_DEFERRED  = 0;
    localparam int unsigned BIT_UNDERRUN  = 1;
    localparam int unsigned BIT_EXC_DEFER = 2;
    localparam int unsigned CNT_LSB       = 3;
    localparam int unsigned CNT_MSB       = 6;
    localparam int unsigned BIT_RSVD      = 7;
    localparam int unsigned BIT_EXC_COLL  = 8;
    localparam int unsigned CORE_W        = 9;
    localparam int unsigned CNT_W         = CNT_MSB - CNT_LSB + 1;

    function automatic logic [CORE_W-1:0] pack_status(
        input logic             deferred,
        input logic             underrun,
        input logic             exc_defer,
        input logic             exc_coll,
        input logic [CNT_W-1:0] coll_cnt
    );
        logic [CORE_W-1:0] w;
        w                   = '0;
        w[BIT_DEFERRED]     = deferred;
        w[BIT_UNDERRUN]     = underrun;
        w[BIT_EXC_DEFER]    = exc_defer;
        w[CNT_MSB:CNT_LSB]  = exc_coll ? '0 : coll_cnt;
        w[BIT_EXC_COLL]     = exc_coll;
        return w;
    endfunction

endpackage

// File: rtl/txst_coll_counter.sv
module txst_coll_counter #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != LAST_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Set when the next collision is the one that reaches the limit
    assign at_last = (cnt == LAST_V);

    AST_COLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt)); // R12

    AST_COLL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !at_last) |=> (cnt == $past(cnt) + 1'b1)); // R3

endmodule

// File: rtl/txst_defer_timer.sv
module txst_defer_timer #(
    parameter int unsigned LIMIT = 24288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic start,
    input  logic stop,
    input  logic tick,
    output logic over,
    output logic seen
);
    localparam int unsigned SAT = LIMIT + 1;
    localparam int unsigned CW  = $clog2(SAT + 1);
    localparam logic [CW-1:0] SAT_V = CW'(SAT);

    logic          deferring_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deferring_q <= 1'b0;
            cnt_q       <= '0;
            seen        <= 1'b0;
        end else if (clr) begin
            deferring_q <= 1'b0;
            cnt_q       <= '0;
            seen        <= 1'b0;
        end else if (en) begin
            if (start) begin
                deferring_q <= 1'b1;
                cnt_q       <= '0;
                seen        <= 1'b1;
            end else begin
                if (stop) begin
                    deferring_q <= 1'b0;
                end
                if (deferring_q && tick && (cnt_q != SAT_V)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign over = (cnt_q == SAT_V);

    AST_DEFER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT_V); // R8

    AST_DEFER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!deferring_q && !clr && !(en && start)) |=> $stable(cnt_q)); // R8

    AST_DEFER_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr && !(en && start)) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/tx_status_tracker.sv
module tx_status_tracker
    import txst_pkg::*;
#(
    parameter int unsigned STATUS_W    = 16,
    parameter int unsigned COLL_LIMIT  = 16,
    parameter int unsigned DEFER_LIMIT = 24288
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                coll_pulse,
    input  logic                defer_begin,
    input  logic                defer_end,
    input  logic                bit_tick,
    input  logic                fifo_underrun,
    input  logic                tx_done,
    input  logic                defer_chk_en,
    input  logic                udf_clr,
    output logic [STATUS_W-1:0] status_word,
    output logic                status_valid,
    output logic                abort_req,
    output logic                udf_err
);
    localparam int unsigned PAD_W = STATUS_W - CORE_W;

    txst_state_e       state_q, state_d;
    txst_end_e         end_d;
    logic              active;
    logic              clr;
    logic [CNT_W-1:0]  coll_cnt;
    logic              coll_last;
    logic              defer_over;
    logic              defer_seen;
    logic [CORE_W-1:0] word_q;
    logic              aborted_q;

    assign active = (state_q == ST_ACTIVE);
    assign clr    = (state_q == ST_IDLE) && frame_start;

    txst_coll_counter #(
        .CNT_W (CNT_W),
        .LIMIT (COLL_LIMIT)
    ) u_coll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .inc     (active && coll_pulse),
        .cnt     (coll_cnt),
        .at_last (coll_last)
    );

    txst_defer_timer #(
        .LIMIT (DEFER_LIMIT)
    ) u_defer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (active),
        .start (defer_begin),
        .stop  (defer_end),
        .tick  (bit_tick),
        .over  (defer_over),
        .seen  (defer_seen)
    );

    // Ending cause, ranked: underrun, collisions, deferral, completion
    always_comb begin
        end_d = END_NONE;
        if (active) begin
            if (fifo_underrun) begin
                end_d = END_UNDERRUN;
            end else if (coll_pulse && coll_last) begin
                end_d = END_EXC_COLL;
            end else if (defer_chk_en && defer_over) begin
                end_d = END_EXC_DEFER;
            end else if (tx_done) begin
                end_d = END_DONE;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frame_start)        state_d = ST_ACTIVE;
            ST_ACTIVE: if (end_d != END_NONE)  state_d = ST_REPORT;
            ST_REPORT:                         state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outcome capture on the ACTIVE->REPORT transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            aborted_q <= 1'b0;
        end else if (end_d != END_NONE) begin
            word_q <= pack_status(defer_seen || defer_begin,
                                  end_d == END_UNDERRUN,
                                  end_d == END_EXC_DEFER,
                                  end_d == END_EXC_COLL,
                                  coll_cnt);
            aborted_q <= (end_d != END_DONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            udf_err <= 1'b0;
        end else if (active && fifo_underrun) begin
            udf_err <= 1'b1;
        end else if (udf_clr) begin
            udf_err <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        status_valid = (state_q == ST_REPORT);
        abort_req    = (state_q == ST_REPORT) && aborted_q;
        status_word  = {{PAD_W{1'b0}}, word_q};
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |=> !status_valid); // R3

    AST_ABORT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> status_valid); // R3

    AST_EXC_COLL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status_word[BIT_EXC_COLL])
            |-> (status_word[CNT_MSB:CNT_LSB] == '0)); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[BIT_RSVD] == 1'b0)
            && (status_word[STATUS_W-1:BIT_EXC_COLL+1] == '0)); // R10

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_err && !udf_clr) |=> udf_err); // R9

    AST_UDF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fifo_underrun) |=> (udf_err && status_valid && abort_req)); // R9

    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> $onehot0({status_word[BIT_EXC_COLL],
                                   status_word[BIT_EXC_DEFER],
                                   status_word[BIT_UNDERRUN]})); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !status_valid); // R12

endmodule

// File: tb/tx_status_tracker_test.sv
`timescale 1ns/1ps
module tx_status_tracker_test;

    localparam int LIMIT = 24288;

    typedef struct packed {
        logic [4:0] ncoll;
        logic [3:0] dticks;
        logic       udf;
        logic [8:0] word;
        logic       abrt;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{5'd0,  4'd0, 1'b0, 9'h000, 1'b0},
        '{5'd3,  4'd0, 1'b0, 9'h018, 1'b0},
        '{5'd15, 4'd0, 1'b0, 9'h078, 1'b0},
        '{5'd0,  4'd5, 1'b0, 9'h001, 1'b0},
        '{5'd7,  4'd2, 1'b0, 9'h039, 1'b0},
        '{5'd2,  4'd0, 1'b1, 9'h012, 1'b1},
        '{5'd0,  4'd3, 1'b1, 9'h003, 1'b1},
        '{5'd9,  4'd1, 1'b1, 9'h04B, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, coll_pulse = 1'b0, defer_begin = 1'b0;
    logic        defer_end = 1'b0, bit_tick = 1'b0, fifo_underrun = 1'b0;
    logic        tx_done = 1'b0, defer_chk_en = 1'b1, udf_clr = 1'b0;
    logic [15:0] status_word;
    logic        status_valid, abort_req, udf_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tx_status_tracker uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .coll_pulse    (coll_pulse),
        .defer_begin   (defer_begin),
        .defer_end     (defer_end),
        .bit_tick      (bit_tick),
        .fifo_underrun (fifo_underrun),
        .tx_done       (tx_done),
        .defer_chk_en  (defer_chk_en),
        .udf_clr       (udf_clr),
        .status_word   (status_word),
        .status_valid  (status_valid),
        .abort_req     (abort_req),
        .udf_err       (udf_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic begin_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic collide(input int n);
        for (int i = 0; i < n; i++) begin
            coll_pulse = 1'b1;
            @(negedge clk);
            coll_pulse = 1'b0;
        end
    endtask

    task automatic short_defer(input int ticks);
        defer_begin = 1'b1;
        @(negedge clk);
        defer_begin = 1'b0;
        bit_tick = 1'b1;
        repeat (ticks) @(negedge clk);
        bit_tick = 1'b0;
        defer_end = 1'b1;
        @(negedge clk);
        defer_end = 1'b0;
    endtask

    // Drive the ending pulse(s) and check the report in the following cycle
    task automatic end_frame(input bit udf, input bit done, input logic [8:0] ew,
                             input bit ea, input string req);
        fifo_underrun = udf;
        tx_done       = done;
        @(negedge clk);
        fifo_underrun = 1'b0;
        tx_done       = 1'b0;
        chk(status_valid == 1'b1, {req, " valid strobe"}, status_valid, 1);
        chk(status_word == {7'd0, ew}, {req, " status word"}, status_word, {7'd0, ew});
        chk(abort_req == ea, {req, " abort"}, abort_req, ea);
        chk((status_word & 16'hFE80) == 16'h0, "R10 reserved bits", status_word, 0);
        @(negedge clk);
        chk(status_valid == 1'b0, "R3 strobe lasts one cycle", status_valid, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(status_valid == 0 && abort_req == 0 && udf_err == 0 && status_word == 0,
            "R1 in reset", {status_valid, abort_req, udf_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status_valid == 0 && abort_req == 0 && udf_err == 0 && status_word == 0,
            "R1 after reset", status_word, 0);

        // Vector table: R3 counts, R5 deferred flag, R9 underrun
        for (int v = 0; v < NVEC; v++) begin
            begin_frame();
            collide(int'(VECS[v].ncoll));
            if (VECS[v].dticks != 0) short_defer(int'(VECS[v].dticks));
            chk(status_valid == 0, "R3 no early strobe", status_valid, 0);
            end_frame(VECS[v].udf, !VECS[v].udf, VECS[v].word, VECS[v].abrt,
                      VECS[v].udf ? "R9 R5 vector" : "R3 R5 vector");
            chk(udf_err == VECS[v].udf, "R9 error flag per vector", udf_err, VECS[v].udf);
            if (VECS[v].udf) begin
                udf_clr = 1'b1;
                @(negedge clk);
                udf_clr = 1'b0;
                chk(udf_err == 0, "R9 clear", udf_err, 0);
            end
        end

        // R4: 16th collision aborts, count field zero
        begin_frame();
        collide(15);
        chk(status_valid == 0, "R4 no abort at 15", status_valid, 0);
        coll_pulse = 1'b1;
        @(negedge clk);
        coll_pulse = 1'b0;
        chk(status_valid == 1 && abort_req == 1, "R4 abort on 16th", {status_valid, abort_req}, 3);
        chk(status_word == 16'h0100, "R4 word", status_word, 16'h0100);
        @(negedge clk);
        chk(status_valid == 0, "R4 strobe ends", status_valid, 0);

        // R2: next attempt starts clean
        begin_frame();
        collide(1);
        end_frame(1'b0, 1'b1, 9'h008, 1'b0, "R2 cleared");

        // R6: excessive deferral, to the cycle
        begin_frame();
        defer_begin = 1'b1;
        @(negedge clk);
        defer_begin = 1'b0;
        bit_tick = 1'b1;
        repeat (LIMIT) @(negedge clk);
        chk(status_valid == 0, "R6 at limit", status_valid, 0);
        @(negedge clk);
        bit_tick = 1'b0;
        chk(status_valid == 0, "R6 reaction pending", status_valid, 0);
        @(negedge clk);
        chk(status_valid == 1 && abort_req == 1, "R6 abort", {status_valid, abort_req}, 3);
        chk(status_word == 16'h0005, "R6 word", status_word, 16'h0005);
        @(negedge clk);

        // R6 boundary and R8: exactly the limit, then ticks outside deferral
        begin_frame();
        defer_begin = 1'b1;
        @(negedge clk);
        defer_begin = 1'b0;
        bit_tick = 1'b1;
        repeat (LIMIT) @(negedge clk);
        bit_tick = 1'b0;
        defer_end = 1'b1;
        @(negedge clk);
        defer_end = 1'b0;
        bit_tick = 1'b1;
        repeat (10) @(negedge clk);
        bit_tick = 1'b0;
        @(negedge clk);
        chk(status_valid == 0, "R8 ticks outside deferral ignored", status_valid, 0);
        end_frame(1'b0, 1'b1, 9'h001, 1'b0, "R6 exact limit no abort");

        // R7: check disabled
        defer_chk_en = 1'b0;
        begin_frame();
        defer_begin = 1'b1;
        @(negedge clk);
        defer_begin = 1'b0;
        bit_tick = 1'b1;
        repeat (LIMIT + 100) @(negedge clk);
        bit_tick = 1'b0;
        chk(status_valid == 0, "R7 no abort when disabled", status_valid, 0);
        defer_end = 1'b1;
        @(negedge clk);
        defer_end = 1'b0;
        end_frame(1'b0, 1'b1, 9'h001, 1'b0, "R7 bit2 clear");
        defer_chk_en = 1'b1;

        // R11: underrun beats completion
        begin_frame();
        collide(2);
        end_frame(1'b1, 1'b1, 9'h012, 1'b1, "R11 priority");

        // R9: sticky across idle and a later good attempt
        repeat (5) @(negedge clk);
        chk(udf_err == 1, "R9 sticky idle", udf_err, 1);
        begin_frame();
        end_frame(1'b0, 1'b1, 9'h000, 1'b0, "R9 clean attempt");
        chk(udf_err == 1, "R9 sticky after attempt", udf_err, 1);
        udf_clr = 1'b1;
        @(negedge clk);
        udf_clr = 1'b0;
        chk(udf_err == 0, "R9 cleared by host", udf_err, 0);

        // R12: events in IDLE are ignored
        coll_pulse = 1'b1; defer_begin = 1'b1; fifo_underrun = 1'b1; tx_done = 1'b1;
        @(negedge clk);
        coll_pulse = 1'b0; defer_begin = 1'b0; fifo_underrun = 1'b0; tx_done = 1'b0;
        chk(status_valid == 0 && udf_err == 0, "R12 idle events", {status_valid, udf_err}, 0);
        @(negedge clk);
        chk(status_valid == 0, "R12 idle no strobe", status_valid, 0);
        begin_frame();
        end_frame(1'b0, 1'b1, 9'h000, 1'b0, "R12 next word clean");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule